// File: doc/BRIEF.md
# Switching-Pattern Memory Reader with Gate Lockout

This block fetches the switching state of a harmonic-elimination PWM pattern from an external asynchronous memory. It drives a pair of complementary gate outputs for each inverter leg. The memory address combines two fields. The upper field is a pattern-set select: three bits pick one of eight sets, holding 3, 5, 7 and so on up to 17 switching angles per quarter period. The lower field is the phase angle already folded into the first quadrant. The block works from one fixed reference clock, nominally 10 MHz. It uses that clock to time the memory access window, the synchronous capture of the returned data and the dead-time of the gate drivers.

A four-state machine runs each read. **IDLE** waits for a reason to read. It leaves for **ADDR** when no read has been done since reset, when the address inputs differ from the last address read, or when a periodic refresh request is pending. **ADDR** registers the address and leaves for **READ_WAIT** after one cycle. **READ_WAIT** holds the read enable for the programmed access time, captures the memory data bus in its last cycle and leaves for **LATCH**. **LATCH** moves the captured data into the pattern register and returns to **IDLE**.

The pattern register is XORed with an invert flag to give the wanted state of each leg. Each leg has its own lockout stage. Whenever the wanted state of a leg differs from the state it is applying, both gates of that leg are turned off for the dead-time. After that, the upper gate takes the new state and the lower gate takes its complement. A gate is enabled only when its leg has been loaded at least once and its dead-time counter has reached zero.

Top module: `pm_reader`

## Requirements
- R1: While the read enable is high, the address output equals {set select, folded angle}, with the set select in the upper IDX_W bits, and it stays stable for the whole read.
- R2: In IDLE, a change of the set select or of the folded angle starts a new read, and the gates then settle to the pattern stored at the new address.
- R3: Each read holds the read enable high for exactly ACC_CYC consecutive cycles (default 2).
- R4: After settling, gate_hi of each leg equals bit l of (captured data XOR invert flag), and gate_lo equals its complement. The memory bus is captured in the last read-enable cycle.
- R5: Toggling the invert flag with no read flips every leg, each leg passing through its dead-time.
- R6: When the wanted state of a leg changes, that leg drives both gates low for exactly DEAD_CYC cycles (default 20). A leg whose wanted state does not change shows no off interval, even when a new read takes place.
- R7: The upper and lower gate of a leg are never high in the same cycle.
- R8: From reset, every gate stays low until the first read has been latched and a full dead-time has elapsed.
- R9: With inputs held steady, a read is started once every REFRESH_CYC cycles (default 512).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_sel | input | IDX_W (3) | Pattern-set (modulation index) select |
| ang_q | input | ANG_W (8) | Phase angle folded into the first quadrant |
| inv | input | 1 | Invert flag applied to the latched state |
| mem_data | input | NLEG (3) | Data bus from the pattern memory |
| mem_addr | output | IDX_W+ANG_W (11) | Pattern memory address |
| mem_rd | output | 1 | Memory read enable |
| gate_hi | output | NLEG (3) | Upper switch gate, one bit per leg |
| gate_lo | output | NLEG (3) | Lower switch gate, one bit per leg |

## Verification
A sequencer stuck in one state, or with its wait counter off by one, appears at mem_rd at once. The enable pulse has the wrong length or never falls, and no new pattern reaches the gates within a few cycles. A wrong capture point or a bad address field shows as wrong gate levels once the dead-time has ended, about 30 cycles after the inputs change. Lockout faults show at the gate ports during the very transition that triggers them. Such a fault may be an off interval one cycle too short or too long, a glitch on a leg that should not change, or both gates on. The same applies to a missing hold-off after reset.

// File: rtl/pm_reader_pkg.sv
package pm_reader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_RWAIT = 2'd2,
        ST_LATCH = 2'd3
    } rd_state_t;

endpackage

// File: rtl/pm_read_seq.sv
module pm_read_seq
    import pm_reader_pkg::*;
#(
    parameter int AW          = 11,
    parameter int NLEG        = 3,
    parameter int ACC_CYC     = 2,
    parameter int REFRESH_CYC = 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   key,
    input  logic [NLEG-1:0] mem_data,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    output logic [NLEG-1:0] samp_q,
    output logic            ld
);
    localparam int CW = $clog2(ACC_CYC + 1);
    localparam int RW = $clog2(REFRESH_CYC + 1);
    localparam logic [CW-1:0] ACC_LAST = CW'(ACC_CYC - 1);
    localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_CYC - 1);

    rd_state_t       st, nx;
    logic [AW-1:0]   addr_q;
    logic [CW-1:0]   cnt;
    logic [RW-1:0]   rtmr;
    logic            have, pend, tick, start, last;

    assign tick  = (rtmr == REF_LAST);
    assign last  = (cnt == ACC_LAST);
    assign start = (st == ST_IDLE) && (nx == ST_ADDR);

    // next-state decision
    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE:  if (!have || pend || key != addr_q) nx = ST_ADDR;
            ST_ADDR:  nx = ST_RWAIT;
            ST_RWAIT: if (last) nx = ST_LATCH;
            ST_LATCH: nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nx;
    end

    // address, timers and capture stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt    <= '0;
            rtmr   <= '0;
            have   <= 1'b0;
            pend   <= 1'b0;
            samp_q <= '0;
        end else begin
            rtmr <= tick ? '0 : rtmr + 1'b1;
            if (tick) pend <= 1'b1;
            if (start) begin
                addr_q <= key;
                have   <= 1'b1;
                pend   <= 1'b0;
            end
            if (st == ST_ADDR)  cnt <= '0;
            if (st == ST_RWAIT) begin
                cnt <= cnt + 1'b1;
                if (last) samp_q <= mem_data;
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr = addr_q;
        mem_rd   = (st == ST_RWAIT);
        ld       = (st == ST_LATCH);
    end

    p_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> $stable(mem_addr));

    p_rd_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && cnt == ACC_LAST) |=> !mem_rd);

    p_key_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && have && key != addr_q) |=> (st == ST_ADDR && addr_q == $past(key)));

    p_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && pend) |=> (st == ST_ADDR));

endmodule

// File: rtl/pm_leg_lock.sv
module pm_leg_lock #(
    parameter int DEAD_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic tgt,
    output logic gh,
    output logic gl
);
    localparam int DW = $clog2(DEAD_CYC + 2);
    localparam logic [DW-1:0] DEAD_LD = DW'(DEAD_CYC);

    logic          cur, armed, chg;
    logic [DW-1:0] cnt;

    assign chg = vld && (!armed || tgt != cur);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= 1'b0;
            armed <= 1'b0;
            cnt   <= '0;
        end else if (chg) begin
            cur   <= tgt;
            armed <= 1'b1;
            cnt   <= DEAD_LD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // gate enable = loaded AND dead-time done
    always_comb begin
        gh = armed && (cnt == '0) && cur;
        gl = armed && (cnt == '0) && !cur;
    end

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n) !(gh && gl));

    p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && DEAD_CYC > 0) |=> (!gh && !gl));

    p_reset_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!gh && !gl));

endmodule

// File: rtl/pm_reader.sv
module pm_reader
    import pm_reader_pkg::*;
#(
    parameter int IDX_W       = 3,
    parameter int ANG_W       = 8,
    parameter int NLEG        = 3,
    parameter int ACC_CYC     = 2,
    parameter int DEAD_CYC    = 20,
    parameter int REFRESH_CYC = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       set_sel,
    input  logic [ANG_W-1:0]       ang_q,
    input  logic                   inv,
    input  logic [NLEG-1:0]        mem_data,
    output logic [IDX_W+ANG_W-1:0] mem_addr,
    output logic                   mem_rd,
    output logic [NLEG-1:0]        gate_hi,
    output logic [NLEG-1:0]        gate_lo
);
    localparam int AW = IDX_W + ANG_W;

    logic [NLEG-1:0] samp_q, lat_q, tgt;
    logic            ld, lat_v;

    pm_read_seq #(
        .AW(AW), .NLEG(NLEG), .ACC_CYC(ACC_CYC), .REFRESH_CYC(REFRESH_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .key({set_sel, ang_q}), .mem_data(mem_data),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .samp_q(samp_q), .ld(ld)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            lat_v <= 1'b0;
        end else if (ld) begin
            lat_q <= samp_q;
            lat_v <= 1'b1;
        end
    end

    assign tgt = lat_q ^ {NLEG{inv}};

    for (genvar l = 0; l < NLEG; l++) begin : g_leg
        pm_leg_lock #(.DEAD_CYC(DEAD_CYC)) u_lock (
            .clk(clk), .rst_n(rst_n), .vld(lat_v), .tgt(tgt[l]),
            .gh(gate_hi[l]), .gl(gate_lo[l])
        );
    end

    p_latch_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> $past(mem_rd));

endmodule

// File: tb/tb_pm_reader.sv
module tb_pm_reader;
    localparam int IDX_W = 3, ANG_W = 8, NLEG = 3;
    localparam int ACC = 2, DEAD = 20, REFR = 512;
    localparam int AW = IDX_W + ANG_W;
    localparam int WIN = 120;

    logic clk = 1'b0, rst_n = 1'b0, inv = 1'b0;
    logic [IDX_W-1:0] set_sel = '0;
    logic [ANG_W-1:0] ang_q = '0;
    logic [NLEG-1:0]  mem_data, gate_hi, gate_lo;
    logic [AW-1:0]    mem_addr;
    logic             mem_rd;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    // pattern memory model: data = angle[2:0] XOR set select
    assign mem_data = mem_addr[2:0] ^ mem_addr[ANG_W +: 3];

    pm_reader dut (
        .clk(clk), .rst_n(rst_n), .set_sel(set_sel), .ang_q(ang_q), .inv(inv),
        .mem_data(mem_data), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // vector: {set_sel[3], ang_q[8], inv[1], expected gate_hi[3]}
    typedef logic [14:0] vec_t;
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        {3'd0, 8'h05, 1'b0, 3'b101},
        {3'd3, 8'h05, 1'b0, 3'b110},
        {3'd3, 8'h05, 1'b1, 3'b001},
        {3'd7, 8'h2A, 1'b1, 3'b010},
        {3'd2, 8'hFF, 1'b0, 3'b101},
        {3'd2, 8'hFF, 1'b0, 3'b101},
        {3'd5, 8'h80, 1'b0, 3'b101},
        {3'd1, 8'h14, 1'b1, 3'b010}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        logic [NLEG-1:0] prev;
        int off_run;
        // R8: reset state and hold-off after reset
        set_sel = VECS[0][14:12]; ang_q = VECS[0][11:4]; inv = VECS[0][3];
        repeat (3) @(negedge clk);
        check(gate_hi == 0 && gate_lo == 0 && !mem_rd, "R8 reset", int'({gate_hi, gate_lo}), 0);
        rst_n = 1'b1;
        off_run = 0;
        for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            if (gate_hi == 0 && gate_lo == 0) off_run++;
            else break;
        end
        check(off_run > DEAD && off_run < WIN, "R8 first enable", off_run, DEAD + 5);
        repeat (WIN) @(negedge clk);
        check(gate_hi == VECS[0][2:0] && gate_lo == ~VECS[0][2:0], "R4 first pattern",
              int'(gate_hi), int'(VECS[0][2:0]));
        prev = VECS[0][2:0];

        // table walk: R1 R2 R3 R4 R5 R6
        for (int v = 1; v < NV; v++) begin
            logic [AW-1:0] key, last_addr;
            logic [NLEG-1:0] exp;
            int gap [NLEG];
            int run, reads, bad_len;
            bit key_chg;
            key = VECS[v][14:4];
            exp = VECS[v][2:0];
            key_chg = (key != {set_sel, ang_q});
            set_sel = VECS[v][14:12]; ang_q = VECS[v][11:4]; inv = VECS[v][3];
            for (int l = 0; l < NLEG; l++) gap[l] = 0;
            run = 0; reads = 0; bad_len = 0; last_addr = '0;
            for (int c = 0; c < WIN; c++) begin
                @(negedge clk);
                for (int l = 0; l < NLEG; l++)
                    if (!gate_hi[l] && !gate_lo[l]) gap[l]++;
                if (mem_rd) begin
                    run++;
                    last_addr = mem_addr;
                end else if (run != 0) begin
                    reads++;
                    if (run != ACC) bad_len = run;
                    run = 0;
                end
            end
            check(gate_hi == exp && gate_lo == ~exp, "R4 gate levels", int'(gate_hi), int'(exp));
            for (int l = 0; l < NLEG; l++) begin
                if (prev[l] != exp[l])
                    check(gap[l] == DEAD, VECS[v][3] != VECS[v-1][3] ? "R5/R6 dead-time" : "R6 dead-time",
                          gap[l], DEAD);
                else
                    check(gap[l] == 0, "R6 unchanged leg", gap[l], 0);
            end
            check(bad_len == 0, "R3 read length", bad_len, ACC);
            if (key_chg) begin
                check(reads >= 1, "R2 read on change", reads, 1);
                check(last_addr == key, "R1 address", int'(last_addr), int'(key));
            end
            prev = exp;
        end

        // R9: periodic refresh with steady inputs
        begin
            int rises;
            logic was;
            rises = 0;
            was = mem_rd;
            for (int c = 0; c < 3 * REFR; c++) begin
                @(negedge clk);
                if (mem_rd && !was) rises++;
                was = mem_rd;
            end
            check(rises == 3, "R9 refresh count", rises, 3);
            check(gate_hi == prev, "R6 refresh no glitch", int'(gate_hi), int'(prev));
        end

        // R7: no overlap, sampled across an invert toggle
        begin
            int both;
            both = 0;
            inv = ~inv;
            for (int c = 0; c < WIN; c++) begin
                @(negedge clk);
                if ((gate_hi & gate_lo) != 0) both++;
            end
            check(both == 0, "R7 no overlap", both, 0);
            check(gate_hi == ~prev, "R5 invert toggle", int'(gate_hi), int'(~prev));
        end

        finish_run();
    end

endmodule